// File: doc/BRIEF.md
# Multichannel Overflow Flag Generator

This block watches the decimated output words of a four-channel converter and raises a single overflow flag whenever any channel comes within a small margin of full scale. Each frame the block receives one signed 24-bit word per channel together with a one-cycle frame strobe. It compares each word's magnitude against a near-full-scale threshold, combines the per-channel results, and passes the combined result through a frame-clocked delay line. The flag therefore lines up with the filtered samples that a downstream consumer sees.

When the power-down control is low, the block is held in reset. When the control rises, a blanking state machine keeps the flag low for a fixed number of frames while the converter settles, and then lets the delayed detection through. The flag is registered and moves only on frame strobes.

The state machine has two states. `ST_BLANK` is entered on reset, and it counts frame strobes. `ST_LIVE` passes the delayed detection to the output. There are three transitions. The reset transition goes from any state to `ST_BLANK` while the power-down control is low. The arm transition goes from `ST_BLANK` to `ST_LIVE` on the strobe that completes the blanking count. The hold transition keeps the machine in `ST_LIVE` until the next reset.

Top module: `ovf_flag_gen`

## Requirements
- R1: A channel is over range when the magnitude of its two's complement word is strictly greater than `OVF_TH` (default 8103800). A magnitude equal to `OVF_TH` is not over range. This holds for both signs.
- R2: The combined detection for a frame is the OR of the four channel results. Channel i occupies bits `[24*i+23 : 24*i]` of `smp_bus`. One over-range channel is enough to set it.
- R3: The most negative code, -2^23, counts as over range. Its magnitude must not wrap.
- R4: After the frame strobe numbered m (counted from 1 since `pd_n` rose), with m > `BLANK_FRAMES`, `ovf` equals the combined detection of strobe m-`DLY_FRAMES` (default 28). If m is not greater than `DLY_FRAMES`, `ovf` is 0.
- R5: For frame strobes 1 to `BLANK_FRAMES` (default 516) after `pd_n` rises, `ovf` stays 0 whatever the samples are.
- R6: While `pd_n` is low, `ovf` is 0 at once. The delay line is cleared, and blanking restarts from strobe 1 when `pd_n` rises again. Samples from before the reset never appear at the output.
- R7: `ovf` changes only on the clock edge that samples `frame_stb` high. Sample values presented without a strobe do not affect `ovf`, now or later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| pd_n | input | 1 | Power-down control, active low. Low holds the block in asynchronous reset |
| frame_stb | input | 1 | One-cycle pulse marking valid samples on `smp_bus` |
| smp_bus | input | 96 | Four signed 24-bit samples, channel 0 in the least significant bits |
| ovf | output | 1 | Delay-aligned, blanked overflow flag |

## Verification
A state machine that arms early or late shows up at the port on the first frame after the 516th strobe. If the delayed history there contains overflow, the flag differs on that same frame. Delay-line faults such as a wrong depth, a missed clear, or a shift without a strobe appear as a flag that leads or lags the expected frame by one or more frames. Such faults can also show as a stale 1 right after blanking. Because of this, the bench fills the blanking window with overflowing samples. A threshold or sign error at the comparator appears exactly 28 frames after the offending sample.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    typedef enum logic [0:0] {
        ST_BLANK = 1'b0,
        ST_LIVE  = 1'b1
    } ovf_state_e;

    localparam int unsigned SMP_W   = 24;
    localparam int unsigned NUM_CH  = 4;

endpackage

// File: rtl/ovf_mag_cmp.sv
module ovf_mag_cmp #(
    parameter int unsigned SW     = 24,
    parameter int unsigned OVF_TH = 8103800
) (
    input  logic [SW-1:0] smp,
    output logic          over
);
    localparam int unsigned MW = SW + 1;
    localparam logic [MW-1:0] TH_V = MW'(OVF_TH);

    logic [MW-1:0] ext;
    logic [MW-1:0] mag;

    always_comb begin
        ext = {smp[SW-1], smp};
        if (smp[SW-1]) begin
            mag = (~ext) + MW'(1);
        end else begin
            mag = ext;
        end
        over = (mag > TH_V);
    end

endmodule

// File: rtl/ovf_delay_line.sv
module ovf_delay_line #(
    parameter int unsigned DEPTH = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic din,
    output logic tap
);
    logic [DEPTH-1:0] dl;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dl <= '0;
                end else if (adv) begin
                    dl <= din;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dl <= '0;
                end else if (adv) begin
                    dl <= {dl[DEPTH-2:0], din};
                end
            end
        end
    endgenerate

    assign tap = dl[DEPTH-1];

    AST_DL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (dl[0] == $past(din)));                          // R4

    AST_DL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(dl));                                   // R7

endmodule

// File: rtl/ovf_blank_fsm.sv
module ovf_blank_fsm
    import ovf_pkg::*;
#(
    parameter int unsigned BLANK_FRAMES = 516
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic tap,
    output logic ovf_q
);
    localparam int unsigned CW = $clog2(BLANK_FRAMES + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK_FRAMES - 1);

    ovf_state_e   state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_BLANK: begin
                if (stb) begin
                    if (cnt == LAST) begin
                        state_nx = ST_LIVE;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + CW'(1);
                    end
                end
            end
            ST_LIVE: begin
                state_nx = ST_LIVE;
            end
            default: begin
                state_nx = ST_BLANK;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BLANK;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (stb) begin
            ovf_q <= (state == ST_LIVE) & tap;
        end
    end

    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK) |-> !ovf_q);                         // R5

    AST_ARM_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_LIVE) |-> $past(stb));                 // R5

    AST_FLAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(ovf_q));                                // R7

endmodule

// File: rtl/ovf_flag_gen.sv
module ovf_flag_gen
    import ovf_pkg::*;
#(
    parameter int unsigned SW           = SMP_W,
    parameter int unsigned NCH          = NUM_CH,
    parameter int unsigned OVF_TH       = 8103800,
    parameter int unsigned DLY_FRAMES   = 28,
    parameter int unsigned BLANK_FRAMES = 516
) (
    input  logic              clk,
    input  logic              pd_n,
    input  logic              frame_stb,
    input  logic [NCH*SW-1:0] smp_bus,
    output logic              ovf
);
    localparam logic [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};

    logic [NCH-1:0] ch_over;
    logic           any_over;
    logic           dl_tap;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            ovf_mag_cmp #(
                .SW     (SW),
                .OVF_TH (OVF_TH)
            ) u_cmp (
                .smp  (smp_bus[i*SW +: SW]),
                .over (ch_over[i])
            );

            AST_MIN_CODE: assert property (@(posedge clk) disable iff (!pd_n)
                (smp_bus[i*SW +: SW] == MOST_NEG) |-> any_over); // R3
        end
    endgenerate

    assign any_over = |ch_over;

    ovf_delay_line #(
        .DEPTH (DLY_FRAMES)
    ) u_dly (
        .clk   (clk),
        .rst_n (pd_n),
        .adv   (frame_stb),
        .din   (any_over),
        .tap   (dl_tap)
    );

    ovf_blank_fsm #(
        .BLANK_FRAMES (BLANK_FRAMES)
    ) u_fsm (
        .clk   (clk),
        .rst_n (pd_n),
        .stb   (frame_stb),
        .tap   (dl_tap),
        .ovf_q (ovf)
    );

    AST_ZERO_SAMPLES_QUIET: assert property (@(posedge clk) disable iff (!pd_n)
        (smp_bus == '0) |-> !any_over);                          // R1

endmodule

// File: tb/ovf_flag_gen_bench.sv
module ovf_flag_gen_bench;
    localparam int CLK_PER = 10;
    localparam int TH      = 8103800;
    localparam int DLY     = 28;
    localparam int BLANK   = 516;
    localparam int MINV    = -8388608;
    localparam int MAXV    = 8388607;

    typedef struct {
        bit    v;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        pd_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [95:0] smp_bus = '0;
    logic        ovf;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    exp_t  sb[$];
    bit    hist[$];
    string htag[$];
    int    idx = 0;

    ovf_flag_gen u_ovf_flag_gen (
        .clk       (clk),
        .pd_n      (pd_n),
        .frame_stb (frame_stb),
        .smp_bus   (smp_bus),
        .ovf       (ovf)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic bit is_over(int v);
        longint m;
        m = (v < 0) ? -longint'(v) : longint'(v);
        return m > longint'(TH);
    endfunction

    function automatic logic [95:0] pack4(int a, int b, int c, int d);
        logic [23:0] x0, x1, x2, x3;
        x0 = a[23:0]; x1 = b[23:0]; x2 = c[23:0]; x3 = d[23:0];
        return {x3, x2, x1, x0};
    endfunction

    task automatic check(bit act, bit exp, string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: ovf=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // driver: computes expected output of this strobe and pushes it
    task automatic frame(int a, int b, int c, int d, string tag);
        exp_t e;
        idx++;
        hist.push_back(is_over(a) | is_over(b) | is_over(c) | is_over(d));
        htag.push_back(tag);
        if (idx <= BLANK) begin
            e.v = 1'b0; e.tag = "R5 blanking";
        end else if (idx <= DLY) begin
            e.v = 1'b0; e.tag = "R4 empty line";
        end else begin
            e.v = hist[idx-1-DLY]; e.tag = htag[idx-1-DLY];
        end
        sb.push_back(e);
        @(negedge clk);
        smp_bus   = pack4(a, b, c, d);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        pd_n = 1'b0;
        #1;
        check(ovf, 1'b0, "R6 reset clears flag");
        hist.delete();
        htag.delete();
        idx = 0;
        repeat (3) @(negedge clk);
        pd_n = 1'b1;
    endtask

    // monitor: pops one expected item per sampled strobe
    initial begin
        forever begin
            @(posedge clk);
            if (frame_stb === 1'b1) begin
                #(CLK_PER/4);
                if (sb.size() == 0) begin
                    check(1'b1, 1'b0, "R7 unexpected strobe");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(ovf, e.v, e.tag);
                end
            end
        end
    end

    initial begin
        #(CLK_PER * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: ovf=%0b expected=done", ovf);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ovf, 1'b0, "R6 reset state");
        pd_n = 1'b1;

        // R5: blanking window filled with overflowing samples
        for (int k = 0; k < BLANK; k++) begin
            frame(0, 0, MINV, 0, "R4 delayed overflow");
        end
        // first live frames replay the blanked history
        for (int k = 0; k < 4; k++) frame(0, 0, 0, 0, "R4 zeros");

        // R7: junk without strobe must not move or enter the flag
        @(negedge clk);
        smp_bus = pack4(MINV, MINV, MINV, MINV);
        repeat (5) begin
            @(negedge clk);
            check(ovf, 1'b1, "R7 no change without strobe");
        end
        frame(0, 0, 0, 0, "R7 junk ignored");

        // threshold patterns
        frame(TH, 0, 0, 0,       "R1 equal positive not over");
        frame(0, TH+1, 0, 0,     "R1 positive above threshold");
        frame(0, 0, 0, -TH,      "R1 equal negative not over");
        frame(0, 0, -TH-1, 0,    "R1 negative above threshold");
        frame(MINV, 0, 0, 0,     "R3 most negative code");
        frame(0, 0, 0, MAXV,     "R1 positive full scale");
        frame(1000, -5, TH, -TH, "R2 none over");
        frame(0, 0, 0, TH+1,     "R2 single channel 3");
        frame(MAXV, MINV, TH+1, -TH-1, "R2 all channels");
        frame(-1, 1, 0, 0,       "R1 small values");
        for (int k = 0; k < DLY + 2; k++) frame(0, MAXV, 0, 0, "R4 tail overflow");

        // R6: reset mid-run with flag high, then blanking restarts
        enter_reset();
        for (int k = 0; k < BLANK + 6; k++) begin
            frame((k % 3 == 0) ? MINV : 0, 0, 0, 0, "R6 restart history");
        end

        repeat (4) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule